// File: doc/BRIEF.md
# Opcode Decode and Next-PC Unit

This combinational unit sits at the front of a small 8-bit processor with a 16-bit address space. It turns the 4-bit opcode nibble into sixteen one-hot decode lines. It forms the two sequential successors of the program counter, PC+2 and PC+4. It chooses the program counter for the following instruction.

Short instructions occupy two bytes. Opcodes 0xA through 0xE occupy four bytes. The last two bytes hold a big-endian absolute target, which arrives on `tgt_addr` and is masked to the address width.

The next-PC choice follows a fixed priority, highest first:

1. a direct jump or call takes the target;
2. otherwise a conditional branch takes its own resolved value, which is either the target or PC+4;
3. otherwise a load or store takes PC+4;
4. everything else takes PC+2.

Top module: `pc_sequencer`

## Requirements
- R1: `op_hot[i]` is 1 exactly when `opcode` equals i, so exactly one of the sixteen lines is high for every opcode value.
- R2: `pc_inc2` equals `pc + 2` modulo 2^AW. Bit 0 is passed through unchanged.
- R3: `pc_inc4` equals `pc + 4` modulo 2^AW. Bits 0 and 1 are passed through unchanged.
- R4: `ret_addr` equals PC+4 for every input, so a call returns past both of its words.
- R5: For opcode 0xA (load) and opcode 0xB (store), `next_pc` equals PC+4.
- R6: For opcode 0xC (jump) and opcode 0xE (call), `next_pc` equals `tgt_addr` masked to AW bits, whatever the flags and the condition field are.
- R7: For opcode 0xD (conditional branch), `next_pc` is the masked target when the condition holds and PC+4 when it does not.
- R8: The condition field `cond` selects a flag through bits 2:1: 0 selects Z, 1 selects C, 2 selects N, and 3 selects V. With `cond[0]`=0 the condition holds when that flag is 1. With `cond[0]`=1 it holds when that flag is 0.
- R9: For opcodes 0x0 through 0x9 and 0xF, `next_pc` equals PC+2, and `tgt_addr`, `cond` and the flags have no effect on it.
- R10: `halted` is 1 exactly when `opcode` is 0xF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc | input | AW | Current program counter |
| opcode | input | 4 | Opcode nibble of the instruction |
| cond | input | 3 | Condition field (low 3 bits of the immediate byte) |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| tgt_addr | input | 16 | Absolute target fetched from PC+2/PC+3 |
| op_hot | output | 16 | One-hot opcode decode |
| pc_inc2 | output | AW | PC+2 |
| pc_inc4 | output | AW | PC+4 |
| ret_addr | output | AW | Return address for a call |
| next_pc | output | AW | Selected program counter for the next instruction |
| halted | output | 1 | Halt opcode present |

## Verification
The bench drives the program counter across the wrap points 0xFFFC through 0xFFFF.

- An incrementer that drops its carry, or that starts the carry at the wrong bit, would give a wrong successor there or would fail to wrap to zero.
- Every condition code is driven with its flag both set and clear, with the other flags set to the opposite value. A wrong flag pairing or a wrong polarity would then send a branch to the target when it should fall through.
- Jump and call are driven with flags and conditions that would make a branch fall through. A priority chain ordered wrongly would then leak PC+4 or PC+2 into a direct jump.
- Short opcodes are driven with random targets. A decoder that matched loosely would then either raise two lines or let the target reach `next_pc`.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [3:0]    opcode,
  input  logic [2:0]    cond,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic          flag_n,
  input  logic          flag_v,
  input  logic [15:0]   tgt_addr,
  output logic [15:0]   op_hot,
  output logic [AW-1:0] pc_inc2,
  output logic [AW-1:0] pc_inc4,
  output logic [AW-1:0] ret_addr,
  output logic [AW-1:0] next_pc,
  output logic          halted
);

  localparam int NSTEP = 2;

  // decode
  for (genvar i = 0; i < 16; i++) begin : g_dec
    assign op_hot[i] = (opcode == 4'(i));
  end

  // ripple incrementers: step s adds 2^(s+1)
  logic [NSTEP-1:0][AW-1:0] sum;
  logic [NSTEP-1:0][AW-1:0] cy;

  for (genvar s = 0; s < NSTEP; s++) begin : g_step
    for (genvar b = 0; b < AW; b++) begin : g_bit
      logic cin;
      if (b == s + 1) begin : g_seed
        assign cin = 1'b1;
      end else if (b == 0) begin : g_low
        assign cin = 1'b0;
      end else begin : g_chain
        assign cin = cy[s][b-1];
      end
      assign sum[s][b] = pc[b] ^ cin;
      assign cy[s][b]  = pc[b] & cin;
    end
  end

  assign pc_inc2  = sum[0];
  assign pc_inc4  = sum[1];
  assign ret_addr = pc_inc4;

  // condition evaluation
  logic flag_sel, taken;
  always_comb begin
    case (cond[2:1])
      2'd0:    flag_sel = flag_z;
      2'd1:    flag_sel = flag_c;
      2'd2:    flag_sel = flag_n;
      default: flag_sel = flag_v;
    endcase
  end
  assign taken = flag_sel ^ cond[0];

  // priority selection
  logic [AW-1:0] tgt, br_val, lvl_seq, lvl_br;
  logic use_long, use_br, use_direct;

  assign tgt        = tgt_addr[AW-1:0];
  assign use_long   = op_hot[4'hA] | op_hot[4'hB];
  assign use_br     = op_hot[4'hD];
  assign use_direct = op_hot[4'hC] | op_hot[4'hE];

  assign br_val  = taken ? tgt : pc_inc4;
  assign lvl_seq = use_long ? pc_inc4 : pc_inc2;
  assign lvl_br  = use_br ? br_val : lvl_seq;
  assign next_pc = use_direct ? tgt : lvl_br;
  assign halted  = op_hot[4'hF];

  always_comb begin
    AST_ONE_LINE: assert ($countones(op_hot) == 1); // R1
    AST_INC2_LOW: assert (pc_inc2[0] == pc[0]); // R2
    AST_INC4_LOW: assert (pc_inc4[1:0] == pc[1:0]); // R3
    AST_INC_GAP: assert (pc_inc4 == AW'(pc_inc2 + AW'(2))); // R3
    if (opcode == 4'hA || opcode == 4'hB)
      AST_LONG_SEQ: assert (next_pc == ret_addr); // R5
    if (opcode == 4'hC || opcode == 4'hE)
      AST_DIRECT: assert (next_pc == tgt_addr[AW-1:0]); // R6
    if (opcode == 4'hD)
      AST_BRANCH_PAIR: assert (next_pc == tgt_addr[AW-1:0] || next_pc == pc_inc4); // R7
    if (opcode <= 4'h9)
      AST_SHORT_SEQ: assert (next_pc == pc_inc2); // R9
    if (halted)
      AST_HALT_LINE: assert (opcode == 4'hF); // R10
  end

endmodule

// File: tb/pc_sequencer_tb.sv
module pc_sequencer_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [AW-1:0] pc;
  logic [3:0]    opcode;
  logic [2:0]    cond;
  logic          fz, fc, fn, fv;
  logic [15:0]   tgt;
  logic [15:0]   op_hot;
  logic [AW-1:0] pc_inc2, pc_inc4, ret_addr, next_pc;
  logic          halted;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  pc_sequencer #(.AW(AW)) u_dut (
    .pc(pc), .opcode(opcode), .cond(cond),
    .flag_z(fz), .flag_c(fc), .flag_n(fn), .flag_v(fv),
    .tgt_addr(tgt), .op_hot(op_hot), .pc_inc2(pc_inc2), .pc_inc4(pc_inc4),
    .ret_addr(ret_addr), .next_pc(next_pc), .halted(halted)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (pc=%0h op=%0h cond=%0d)",
               req, act, exp, pc, opcode, cond);
    end
  endtask

  function automatic bit ref_taken(input logic [2:0] c, input bit z, input bit cf,
                                   input bit n, input bit v);
    bit f;
    if (c < 2) f = z;
    else if (c < 4) f = cf;
    else if (c < 6) f = n;
    else f = v;
    return (c % 2 == 0) ? f : !f;
  endfunction

  // checked on the falling edge, inputs change on the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      int p2, p4, np;
      string rq;
      p2 = (int'(pc) + 2) % 65536;
      p4 = (int'(pc) + 4) % 65536;
      chk("R1", op_hot, 1 << opcode);
      chk("R2", pc_inc2, p2);
      chk("R3", pc_inc4, p4);
      chk("R4", ret_addr, p4);
      chk("R10", halted, opcode == 4'hF);
      if (opcode == 4'hA || opcode == 4'hB) begin np = p4; rq = "R5"; end
      else if (opcode == 4'hC || opcode == 4'hE) begin np = tgt; rq = "R6"; end
      else if (opcode == 4'hD) begin
        np = ref_taken(cond, fz, fc, fn, fv) ? int'(tgt) : p4;
        rq = "R7/R8";
      end
      else begin np = p2; rq = "R9"; end
      chk(rq, next_pc, np);
    end
  end

  task automatic apply(input logic [AW-1:0] p, input logic [3:0] o, input logic [2:0] c,
                       input logic [3:0] f, input logic [15:0] t);
    @(posedge clk);
    #1;
    pc = p; opcode = o; cond = c;
    {fv, fn, fc, fz} = f;
    tgt = t;
  endtask

  initial begin
    pc = '0; opcode = '0; cond = '0; {fv, fn, fc, fz} = '0; tgt = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // every opcode at zero inputs and at the wrap points (R1, R2, R3, R10)
    for (int o = 0; o < 16; o++) begin
      apply('0, 4'(o), 3'd0, 4'h0, 16'h0000);
      apply(16'hFFFE, 4'(o), 3'd1, 4'hF, 16'h1234);
      apply(16'hFFFF, 4'(o), 3'd6, 4'h5, 16'hBEEF);
      apply(16'hFFFC, 4'(o), 3'd3, 4'hA, 16'h0002);
      apply(16'hFFFD, 4'(o), 3'd7, 4'h0, 16'hFFFF);
    end
    // R8: each code with its flag set and clear, other flags opposite
    for (int c = 0; c < 8; c++) begin
      for (int fb = 0; fb < 2; fb++) begin
        logic [3:0] fl;
        int idx;
        idx = (c / 2 == 0) ? 0 : (c / 2 == 1) ? 1 : (c / 2 == 2) ? 2 : 3;
        fl = fb ? 4'h0 : 4'hF;
        fl[idx] = fb[0];
        apply(16'h0100, 4'hD, 3'(c), fl, 16'h4000);
        apply(16'hFFFC, 4'hD, 3'(c), fl, 16'h0000);
      end
    end
    // R6: direct jumps with conditions that would fall through
    apply(16'h2000, 4'hC, 3'd0, 4'h0, 16'h00AA);
    apply(16'h2000, 4'hE, 3'd1, 4'h1, 16'h5555);
    // random sweep
    for (int k = 0; k < 3000; k++)
      apply(16'($urandom), 4'($urandom), 3'($urandom), 4'($urandom), 16'($urandom));
    @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule